// File: doc/BRIEF.md
# Fixed-Point Square Root Unit

This block computes the square root of an unsigned fixed-point radicand. The radicand has `INT_W` integer bits and `FRAC_W` fraction bits. The root has `ceil(INT_W/2)` integer bits and `FRAC_W` fraction bits, and the fraction is truncated.

An operand is accepted through a valid/ready handshake, and only one operation runs at a time.

The operand first passes through a two-cycle alignment stage. That stage widens the radicand to an even bit count and scales it by `2^FRAC_W`. A restoring digit-by-digit core then runs on the result. Each iteration shifts two radicand bits into a partial remainder, makes one trial subtraction and produces one root bit.

One further register presents the root together with a one-cycle valid pulse. The latency is therefore fixed by the two widths alone and does not depend on the data.

Top module: `fxsqrt_unit`

## Requirements
- R1: With `RI = (INT_W+1)/2`, the input `in_radicand` is `INT_W+FRAC_W` bits wide and the output `out_root` is `RI+FRAC_W` bits wide. In both, the binary point sits `FRAC_W` bits above bit 0.
- R2: `out_root` equals the largest integer `r` for which `r*r <= in_radicand * 2^FRAC_W`. This is the exact root truncated to `FRAC_W` fraction bits.
- R3: `out_valid` rises a fixed `LAT = (INT_W+1)/2 + FRAC_W + 3` rising clock edges after the edge that accepted the operand (`in_valid && in_ready`). Two of those edges are spent in the alignment stage.
- R4: `in_ready` is high only while no operation is in flight. It drops on the accepting edge and returns high on the same edge that raises `out_valid`.
- R5: `out_valid` is high for exactly one clock cycle per accepted operand.
- R6: A zero radicand yields a zero root after the same latency `LAT`.
- R7: `in_valid` asserted while `in_ready` is low is ignored. It starts no operation and produces no extra result.
- R8: After reset, `in_ready` is 1, `out_valid` is 0 and `out_root` is 0.
- R9: `out_root` holds the last result until the next result is presented.
- R10: The largest radicand (all ones) returns the correct truncated root without overflowing the root width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Unit idle, operand will be taken |
| in_radicand | input | INT_W+FRAC_W | Unsigned fixed-point radicand |
| out_valid | output | 1 | One-cycle result strobe |
| out_root | output | (INT_W+1)/2+FRAC_W | Truncated fixed-point root |

## Verification
The bench builds the unit with `INT_W=7` and `FRAC_W=6`, giving a 13-bit radicand, a 10-bit root and `LAT=13`. The odd integer width forces the alignment stage to pad one zero bit above the radicand, so the pairing of radicand bits is tested where it is most likely to go wrong. The small total width lets random operands reach the all-ones and near-perfect-square values often. The short latency also leaves room for hundreds of operations, some of them with `in_valid` held high throughout the busy window.

// File: rtl/fxsqrt_pkg.sv
package fxsqrt_pkg;

  // Integer bits of the root: two radicand bits resolve one root bit.
  function automatic int root_int_bits(input int iw);
    return (iw + 1) / 2;
  endfunction

  // Edges from accept to result strobe: 2 alignment + one per root bit + 1 output.
  function automatic int op_latency(input int iw, input int fw);
    return (iw + 2 - 1) / 2 + fw + 3;
  endfunction

endpackage

// File: rtl/fxsqrt_align.sv
module fxsqrt_align #(
  parameter int IN_W   = 13,
  parameter int FRAC_W = 6,
  parameter int RAD_W  = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [IN_W-1:0]  din,
  output logic             aligned_v,
  output logic [RAD_W-1:0] aligned
);

  localparam int PAD_W = RAD_W - IN_W - FRAC_W;

  logic            s1_v;
  logic [IN_W-1:0] s1_q;
  logic [RAD_W-1:0] scaled;

  // Widen to an even bit count (pad above when INT_W is odd), then scale by 2^FRAC_W.
  generate
    if (PAD_W > 0) begin : g_pad
      assign scaled = {{PAD_W{1'b0}}, s1_q, {FRAC_W{1'b0}}};
    end else begin : g_nopad
      assign scaled = {s1_q, {FRAC_W{1'b0}}};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v      <= 1'b0;
      s1_q      <= '0;
      aligned_v <= 1'b0;
      aligned   <= '0;
    end else begin
      s1_v      <= take;
      if (take) s1_q <= din;
      aligned_v <= s1_v;
      if (s1_v) aligned <= scaled;
    end
  end

  // Each accepted operand reaches the core exactly two edges later.
  assert_align_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
    s1_v |=> aligned_v);

endmodule

// File: rtl/fxsqrt_core.sv
module fxsqrt_core #(
  parameter int ROOT_W = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [2*ROOT_W-1:0]   rad_in,
  output logic                  fin,
  output logic [ROOT_W-1:0]     root
);

  localparam int RAD_W = 2 * ROOT_W;
  localparam int REM_W = ROOT_W + 1;
  localparam int CND_W = REM_W + 2;
  localparam int CNT_W = $clog2(ROOT_W + 1);

  logic [RAD_W-1:0] rad_q;
  logic [REM_W-1:0] rem_q;
  logic [ROOT_W-1:0] root_q;
  logic [CNT_W-1:0] cnt_q;
  logic             active_q;

  // Named internal events
  logic [CND_W-1:0] cand;
  logic [CND_W-1:0] trial;
  logic             step_take;
  logic             last_step;
  logic [REM_W-1:0] rem_nxt;
  logic [ROOT_W-1:0] root_nxt;

  function automatic logic [CND_W-1:0] trial_of(input logic [ROOT_W-1:0] r);
    return {1'b0, r, 2'b01};
  endfunction

  always_comb begin
    cand      = {rem_q, rad_q[RAD_W-1 -: 2]};
    trial     = trial_of(root_q);
    step_take = (cand >= trial);
    rem_nxt   = step_take ? REM_W'(cand - trial) : REM_W'(cand);
    root_nxt  = {root_q[ROOT_W-2:0], step_take};
    last_step = active_q && (cnt_q == CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rad_q    <= '0;
      rem_q    <= '0;
      root_q   <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
      fin      <= 1'b0;
    end else if (load) begin
      rad_q    <= rad_in;
      rem_q    <= '0;
      root_q   <= '0;
      cnt_q    <= CNT_W'(ROOT_W);
      active_q <= 1'b1;
      fin      <= 1'b0;
    end else if (active_q) begin
      rad_q    <= rad_q << 2;
      rem_q    <= rem_nxt;
      root_q   <= root_nxt;
      cnt_q    <= cnt_q - CNT_W'(1);
      active_q <= !last_step;
      fin      <= last_step;
    end else begin
      fin      <= 1'b0;
    end
  end

  assign root = root_q;

  // Restoring invariant: final remainder never exceeds twice the root.
  assert_rem_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> ({1'b0, rem_q} <= {1'b0, root_q, 1'b0}));

  // A new operand never lands on a running iteration.
  assert_no_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !active_q);

  // Completion is a single-cycle event.
  assert_fin_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !fin);

endmodule

// File: rtl/fxsqrt_unit.sv
module fxsqrt_unit #(
  parameter int INT_W  = 7,
  parameter int FRAC_W = 6
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         in_valid,
  output logic                                         in_ready,
  input  logic [INT_W+FRAC_W-1:0]                      in_radicand,
  output logic                                         out_valid,
  output logic [fxsqrt_pkg::root_int_bits(INT_W)+FRAC_W-1:0] out_root
);
  import fxsqrt_pkg::*;

  localparam int IN_W   = INT_W + FRAC_W;
  localparam int RI     = root_int_bits(INT_W);
  localparam int ROOT_W = RI + FRAC_W;
  localparam int RAD_W  = 2 * ROOT_W;
  localparam int LAT    = op_latency(INT_W, FRAC_W);
  localparam int LCNT_W = $clog2(LAT + 2);

  logic              busy_q;
  logic              accept;
  logic              aligned_v;
  logic [RAD_W-1:0]  aligned;
  logic              core_fin;
  logic [ROOT_W-1:0] core_root;
  logic [LCNT_W-1:0] lat_q;

  assign accept   = in_valid && !busy_q;
  assign in_ready = !busy_q;

  fxsqrt_align #(.IN_W(IN_W), .FRAC_W(FRAC_W), .RAD_W(RAD_W)) align_i (
    .clk(clk), .rst_n(rst_n), .take(accept), .din(in_radicand),
    .aligned_v(aligned_v), .aligned(aligned)
  );

  fxsqrt_core #(.ROOT_W(ROOT_W)) core_i (
    .clk(clk), .rst_n(rst_n), .load(aligned_v), .rad_in(aligned),
    .fin(core_fin), .root(core_root)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      out_valid <= 1'b0;
      out_root  <= '0;
    end else begin
      out_valid <= core_fin;
      if (core_fin) begin
        out_root <= core_root;
        busy_q   <= 1'b0;
      end else if (accept) begin
        busy_q   <= 1'b1;
      end
    end
  end

  // Edge counter since accept, kept for the latency check only.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '0;
    else if (accept) lat_q <= '0;
    else if (busy_q) lat_q <= lat_q + LCNT_W'(1);
  end

  assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (lat_q == LCNT_W'(LAT)));

  assert_ready_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);

  assert_strobe_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_result_only_when_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    core_fin |-> busy_q);

  assert_root_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_root));

endmodule

// File: tb/fxsqrt_unit_tb_top.sv
`timescale 1ns/1ps
module fxsqrt_unit_tb_top;

  localparam int IW    = 7;
  localparam int FW    = 6;
  localparam int IN_W  = IW + FW;
  localparam int OUT_W = (IW + 1) / 2 + FW;
  localparam int LAT   = (IW + 1) / 2 + FW + 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [IN_W-1:0]  in_radicand = '0;
  logic             out_valid;
  logic [OUT_W-1:0] out_root;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cycles++;

  fxsqrt_unit #(.INT_W(IW), .FRAC_W(FW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_radicand(in_radicand), .out_valid(out_valid), .out_root(out_root)
  );

  // Reference: set root bits greedily from the top while the square still fits.
  function automatic longint ref_root(input longint v);
    longint x = v << FW;
    longint r = 0;
    for (int b = OUT_W - 1; b >= 0; b--) begin
      longint t = r | (longint'(1) << b);
      if (t * t <= x) r = t;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [IN_W-1:0] v, input bit junk);
    int k;
    longint exp;
    exp = ref_root(longint'(v));
    @(negedge clk);
    chk(in_ready == 1'b1, "R4 idle ready", longint'(in_ready), 1);
    in_valid    = 1'b1;
    in_radicand = v;
    @(posedge clk);
    @(negedge clk);
    in_valid    = junk;
    in_radicand = IN_W'($urandom);
    chk(in_ready == 1'b0, "R4 busy", longint'(in_ready), 0);
    k = 0;
    while (!out_valid && k < LAT + 5) begin
      @(posedge clk);
      k++;
      @(negedge clk);
      if (junk) in_radicand = IN_W'($urandom);
    end
    in_valid = 1'b0;
    chk(k == LAT, (v == 0) ? "R6 zero latency" : "R3 latency", k, LAT);
    chk(longint'(out_root) == exp,
        (v == 0) ? "R6 zero root" : (&v) ? "R10 max root" : "R2 root",
        longint'(out_root), exp);
    chk(in_ready == 1'b1, "R4 ready with strobe", longint'(in_ready), 1);
    @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R5 single-cycle strobe", longint'(out_valid), 0);
    chk(longint'(out_root) == exp, "R9 hold", longint'(out_root), exp);
    if (junk) begin
      for (int i = 0; i < LAT + 2; i++) begin
        @(negedge clk);
        chk(out_valid == 1'b0, "R7 ignored offer", longint'(out_valid), 0);
      end
      chk(longint'(out_root) == exp, "R7 root untouched", longint'(out_root), exp);
    end
  endtask

  initial begin : watchdog
    wait (cycles >= 190000);
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, 190000);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5a17));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R8 reset ready", longint'(in_ready), 1);
    chk(out_valid == 1'b0, "R8 reset valid", longint'(out_valid), 0);
    chk(out_root == '0, "R8 reset root", longint'(out_root), 0);
    chk($bits(out_root) == OUT_W && $bits(in_radicand) == IN_W, "R1 widths",
        $bits(out_root), OUT_W);

    run_op('0, 1'b0);                        // R6
    run_op('1, 1'b0);                        // R10
    run_op(IN_W'(1), 1'b0);                  // smallest nonzero
    run_op(IN_W'(1 << FW), 1'b0);            // 1.0 -> 1.0
    run_op(IN_W'(4 << FW), 1'b0);            // 4.0 -> 2.0
    run_op(IN_W'(2 << FW), 1'b1);            // 2.0, offers while busy (R7)
    run_op('0, 1'b1);                        // zero with offers while busy
    for (int n = 0; n < 400; n++) begin
      run_op(IN_W'($urandom), ($urandom % 4) == 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule